// File: doc/BRIEF.md
# Sa-Bit Serial Link Interface

This block carries a low-rate serial data link inside the spare (Sa) bits of timeslot 0 of an E1 stream. It sits beside the frame timing logic and takes that logic's timeslot counter, bit counter and frame-parity flag as inputs. Frame alignment search is done elsewhere. One clock cycle is one E1 bit period.

On the transmit side, the block issues a demand clock pulse one bit period before each Sa position that the host has given to the link. It samples the link input at the end of that pulse and puts the sampled bit into the outgoing stream. Sa positions that the host has not given to the link are filled from a host-written default pattern. When insertion is switched off, the stream passes through untouched. On the receive side, each Sa bit whose position is enabled in the receive mask is presented on a link output together with a one-cycle demand clock pulse.

The average demand clock rate is 4 kHz for each enabled position. It therefore ranges from 4 kHz with one position enabled to 20 kHz with all five enabled.

Top module: `sa_link_if`

## Requirements
- R1: An Sa position is a cycle where the timeslot counter is 0, the frame-parity flag is 1 (a frame without the alignment signal), and the bit counter (0 = first-sent MSB) is 3 to 7. Mask and default bit k belong to bit counter value 3+k.
- R2: With insertion on, `tx_lclk` is high for exactly one cycle in the cycle after the counters show a transmit-enabled Sa position, which is one bit period before that bit appears on `tx_dout`.
- R3: `tx_link` is sampled on the clock edge that ends a `tx_lclk`-high cycle, and it appears on `tx_dout` in the next cycle.
- R4: With insertion on, an Sa position whose `tx_mask` bit is 0 is sent as the matching `tx_dflt` bit.
- R5: With insertion off, `tx_lclk` stays low and every bit leaves unchanged.
- R6: Every bit that is not an Sa position, including every bit of frames that carry the alignment signal, appears on `tx_dout` unchanged two cycles after it is presented on `tx_din`.
- R7: Over any 512 consecutive cycles with fixed settings, `tx_lclk` pulses popcount(`tx_mask`) times and `rx_lclk` pulses popcount(`rx_mask`) times.
- R8: When the receive counters show an Sa position whose `rx_mask` bit is 1, then in the next cycle `rx_lclk` is high for one cycle and `rx_link` shows that received bit. `rx_link` holds that value until the next such bit.
- R9: While `rst` is high, all outputs are 0 in the cycle after the edge.
- R10: Receive positions whose `rx_mask` bit is 0, and all non-Sa bits, raise no `rx_lclk` and leave `rx_link` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one cycle per E1 bit |
| rst | input | 1 | Synchronous active-high reset |
| tx_ts | input | 5 | Transmit timeslot counter |
| tx_bit | input | 3 | Transmit bit-in-timeslot counter, 0 = MSB |
| tx_nfas | input | 1 | 1 in transmit frames without the alignment signal |
| tx_din | input | 1 | Outgoing stream before Sa insertion |
| tx_ins_en | input | 1 | Enables Sa insertion |
| tx_mask | input | 5 | Transmit Sa positions given to the link |
| tx_dflt | input | 5 | Values for Sa positions not given to the link |
| tx_link | input | 1 | Transmit link data |
| tx_dout | output | 1 | Outgoing stream after insertion |
| tx_lclk | output | 1 | Transmit demand clock |
| rx_ts | input | 5 | Receive timeslot counter |
| rx_bit | input | 3 | Receive bit-in-timeslot counter |
| rx_nfas | input | 1 | 1 in receive frames without the alignment signal |
| rx_din | input | 1 | Received stream |
| rx_mask | input | 5 | Receive Sa positions given to the link |
| rx_link | output | 1 | Receive link data |
| rx_lclk | output | 1 | Receive demand clock |

## Verification
The transmit path is run with all five positions enabled, with a single middle position, and with a sparse mask paired with a complementary default. Together these separate link-sourced bits from default-sourced bits and show whether the mask-to-bit mapping is shifted. A run with insertion off checks that no pulse appears and that the stream is transparent. Pulse counts over whole 512-cycle periods show the rate scaling. The receive path runs at a different phase from transmit, using masks that differ from the transmit masks, and a reset in the middle of a run checks that the held link bit is cleared.

// File: rtl/sa_link_pkg.sv
package sa_link_pkg;
  localparam int SA_COUNT  = 5;   // Sa positions per timeslot 0
  localparam int SA_BASE   = 3;   // bit counter value of first Sa bit
  localparam int TSLOT_W   = 5;
  localparam int BITCNT_W  = 3;
  typedef logic [SA_COUNT-1:0] sa_vec_t;
endpackage

// File: rtl/sa_pos_decode.sv
module sa_pos_decode
  import sa_link_pkg::*;
#(
  parameter int TS_W    = TSLOT_W,
  parameter int BIT_W   = BITCNT_W,
  parameter int SA_N    = SA_COUNT,
  parameter int SA_FIRST = SA_BASE
) (
  input  logic [TS_W-1:0]  ts,
  input  logic [BIT_W-1:0] bit_idx,
  input  logic             nfas,
  output logic [SA_N-1:0]  sa_oh
);
  logic slot0_nfas;
  assign slot0_nfas = (ts == '0) && nfas;

  for (genvar k = 0; k < SA_N; k++) begin : g_pos
    assign sa_oh[k] = slot0_nfas && (bit_idx == BIT_W'(SA_FIRST + k));
  end
endmodule

// File: rtl/sa_tx_insert.sv
module sa_tx_insert #(
  parameter int SA_N = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SA_N-1:0] sa_oh,
  input  logic            ins_en,
  input  logic [SA_N-1:0] mask,
  input  logic [SA_N-1:0] dflt,
  input  logic            din,
  input  logic            link_in,
  output logic            dout,
  output logic            lclk
);
  logic pos_hit, take_link, take_dflt, dflt_bit;
  logic s1_din, s1_link;

  assign pos_hit   = |sa_oh;
  assign take_link = ins_en && |(sa_oh & mask);
  assign take_dflt = ins_en && pos_hit && !(|(sa_oh & mask));
  assign dflt_bit  = |(sa_oh & dflt);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_din  <= 1'b0;
      s1_link <= 1'b0;
      lclk    <= 1'b0;
      dout    <= 1'b0;
    end else begin
      s1_din  <= take_dflt ? dflt_bit : din;
      s1_link <= take_link;
      lclk    <= take_link;
      dout    <= s1_link ? link_in : s1_din;
    end
  end

  // R3: bit sampled at the end of the pulse is the next output bit
  a_r3_link_follows_clk: assert property (@(posedge clk) disable iff (rst)
    lclk |=> (dout == $past(link_in)));
  // R5: no demand clock when insertion is off
  a_r5_no_clk_when_off: assert property (@(posedge clk) disable iff (rst)
    !ins_en |=> !lclk);
  // R2: a pulse only follows an Sa position
  a_r2_clk_after_sa: assert property (@(posedge clk) disable iff (rst)
    lclk |-> $past(pos_hit));
  // R6: non-Sa bits pass with two cycles of latency
  a_r6_passthrough: assert property (@(posedge clk) disable iff (rst)
    !pos_hit |-> ##2 (dout == $past(din, 2)));
endmodule

// File: rtl/sa_rx_extract.sv
module sa_rx_extract #(
  parameter int SA_N = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SA_N-1:0] sa_oh,
  input  logic [SA_N-1:0] mask,
  input  logic            din,
  output logic            link,
  output logic            lclk
);
  logic take;
  assign take = |(sa_oh & mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      link <= 1'b0;
      lclk <= 1'b0;
    end else begin
      lclk <= take;
      if (take) link <= din;
    end
  end

  // R8: output bit is the bit received in the marked cycle
  a_r8_link_matches: assert property (@(posedge clk) disable iff (rst)
    lclk |-> (link == $past(din)));
  // R10: non-Sa cycles leave the receive link untouched
  a_r10_hold_off_sa: assert property (@(posedge clk) disable iff (rst)
    !(|sa_oh) |=> (!lclk && $stable(link)));
endmodule

// File: rtl/sa_link_if.sv
module sa_link_if
  import sa_link_pkg::*;
#(
  parameter int TS_W     = TSLOT_W,
  parameter int BIT_W    = BITCNT_W,
  parameter int SA_N     = SA_COUNT,
  parameter int SA_FIRST = SA_BASE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TS_W-1:0]  tx_ts,
  input  logic [BIT_W-1:0] tx_bit,
  input  logic             tx_nfas,
  input  logic             tx_din,
  input  logic             tx_ins_en,
  input  logic [SA_N-1:0]  tx_mask,
  input  logic [SA_N-1:0]  tx_dflt,
  input  logic             tx_link,
  output logic             tx_dout,
  output logic             tx_lclk,
  input  logic [TS_W-1:0]  rx_ts,
  input  logic [BIT_W-1:0] rx_bit,
  input  logic             rx_nfas,
  input  logic             rx_din,
  input  logic [SA_N-1:0]  rx_mask,
  output logic             rx_link,
  output logic             rx_lclk
);
  logic [SA_N-1:0] tx_oh, rx_oh;

  sa_pos_decode #(.TS_W(TS_W), .BIT_W(BIT_W), .SA_N(SA_N), .SA_FIRST(SA_FIRST))
    u_tx_pos (.ts(tx_ts), .bit_idx(tx_bit), .nfas(tx_nfas), .sa_oh(tx_oh));

  sa_pos_decode #(.TS_W(TS_W), .BIT_W(BIT_W), .SA_N(SA_N), .SA_FIRST(SA_FIRST))
    u_rx_pos (.ts(rx_ts), .bit_idx(rx_bit), .nfas(rx_nfas), .sa_oh(rx_oh));

  sa_tx_insert #(.SA_N(SA_N)) u_tx (
    .clk(clk), .rst(rst), .sa_oh(tx_oh), .ins_en(tx_ins_en),
    .mask(tx_mask), .dflt(tx_dflt), .din(tx_din), .link_in(tx_link),
    .dout(tx_dout), .lclk(tx_lclk));

  sa_rx_extract #(.SA_N(SA_N)) u_rx (
    .clk(clk), .rst(rst), .sa_oh(rx_oh), .mask(rx_mask), .din(rx_din),
    .link(rx_link), .lclk(rx_lclk));
endmodule

// File: tb/tb_sa_link_if.sv
`timescale 1ns/1ps
module tb_sa_link_if;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] tx_ts = '0, rx_ts = '0;
  logic [2:0] tx_bit = '0, rx_bit = '0;
  logic tx_nfas = 1'b0, rx_nfas = 1'b0;
  logic tx_din = 1'b0, tx_link = 1'b0, rx_din = 1'b0, tx_ins_en = 1'b0;
  logic [4:0] tx_mask = '0, tx_dflt = '0, rx_mask = '0;
  logic tx_dout, tx_lclk, rx_link, rx_lclk;

  always #10 clk = ~clk;

  sa_link_if dut (.*);

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [11:0] pos = 12'd100;
  logic [15:0] lfsr = 16'hACE1;

  // history: 0 = inputs of the cycle just clocked, 1 = the cycle before
  logic h0_hit, h1_hit, h0_din, h1_din, h0_link, h0_ins, h1_ins;
  int   h0_k, h1_k, r0_k;
  logic [4:0] h0_mask, h1_mask, h1_dflt, h0_dflt, r0_mask;
  logic r0_hit, r0_din, exp_rlink;
  int vcnt = 0, rcnt = 0;

  task automatic chk(string tag, logic act, logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0b exp=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic is_sa(logic [4:0] ts, logic [2:0] b, logic nf);
    return (ts == 0) && nf && (b >= 3);
  endfunction

  task automatic step(output logic tl, output logic rl);
    logic [11:0] q;
    logic e_l, e_d, e_rl;
    string tg;
    h1_hit = h0_hit; h1_din = h0_din; h1_ins = h0_ins; h1_k = h0_k;
    h1_mask = h0_mask; h1_dflt = h0_dflt;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    pos = pos + 1'b1;
    q = pos + 12'd1234;
    tx_ts = pos[7:3]; tx_bit = pos[2:0]; tx_nfas = pos[8];
    rx_ts = q[7:3];   rx_bit = q[2:0];   rx_nfas = q[8];
    tx_din = lfsr[0]; tx_link = lfsr[5]; rx_din = lfsr[9];
    h0_hit = is_sa(tx_ts, tx_bit, tx_nfas); h0_k = int'(tx_bit) - 3;
    h0_din = tx_din; h0_link = tx_link; h0_ins = tx_ins_en;
    h0_mask = tx_mask; h0_dflt = tx_dflt;
    r0_hit = is_sa(rx_ts, rx_bit, rx_nfas); r0_k = int'(rx_bit) - 3;
    r0_din = rx_din; r0_mask = rx_mask;
    vcnt++; rcnt++;
    @(negedge clk);
    tl = tx_lclk; rl = rx_lclk;
    // R1 R2: demand clock position and timing
    e_l = h0_ins && h0_hit && h0_mask[h0_k[2:0]];
    chk("R1 R2 tx_lclk", tx_lclk, e_l);
    if (vcnt >= 2) begin
      if (h1_ins && h1_hit) begin
        if (h1_mask[h1_k[2:0]]) begin e_d = h0_link; tg = "R3 tx_dout link"; end
        else begin e_d = h1_dflt[h1_k[2:0]]; tg = "R4 tx_dout default"; end
      end else begin
        e_d = h1_din;
        tg = h1_ins ? "R6 tx_dout passthru" : "R5 tx_dout off";
      end
      chk(tg, tx_dout, e_d);
    end
    e_rl = r0_hit && r0_mask[r0_k[2:0]];
    if (e_rl) exp_rlink = r0_din;
    chk(e_rl ? "R8 rx_lclk" : "R10 rx_lclk", rx_lclk, e_rl);
    chk(e_rl ? "R8 rx_link" : "R10 rx_link", rx_link, exp_rlink);
  endtask

  task automatic run(int n, output int tp, output int rp);
    logic a, b;
    tp = 0; rp = 0;
    for (int i = 0; i < n; i++) begin
      step(a, b);
      tp += int'(a); rp += int'(b);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 tx_dout", tx_dout, 1'b0);
    chk("R9 tx_lclk", tx_lclk, 1'b0);
    chk("R9 rx_link", rx_link, 1'b0);
    chk("R9 rx_lclk", rx_lclk, 1'b0);
    rst = 1'b0;
    vcnt = 0; rcnt = 0; exp_rlink = 1'b0;
    h0_hit = 0; h0_ins = 0; h0_k = 0; h0_mask = '0; h0_dflt = '0; h0_din = 0;
  endtask

  task automatic scen(string name, logic ins, logic [4:0] m, logic [4:0] d,
                      logic [4:0] rm, int periods);
    int tp, rp;
    tx_ins_en = ins; tx_mask = m; tx_dflt = d; rx_mask = rm;
    run(512 * periods, tp, rp);
    // R7: pulse count scales with enabled positions
    chk({"R7 tx pulses ", name}, 1'b1, 1'b1);
    nchk--;
    if (tp != (ins ? $countones(m) : 0) * periods) begin
      nchk++; nfail++;
      $display("FAIL R7 %s tx pulses act=%0d exp=%0d", name, tp,
               (ins ? $countones(m) : 0) * periods);
    end else nchk++;
    if (rp != $countones(rm) * periods) begin
      nchk++; nfail++;
      $display("FAIL R7 %s rx pulses act=%0d exp=%0d", name, rp,
               $countones(rm) * periods);
    end else nchk++;
  endtask

  task automatic t_full();   scen("full",   1'b1, 5'b11111, 5'b00000, 5'b11111, 2); endtask
  task automatic t_single(); scen("single", 1'b1, 5'b00100, 5'b11011, 5'b00001, 2); endtask
  task automatic t_sparse(); scen("sparse", 1'b1, 5'b10010, 5'b01101, 5'b01001, 3); endtask
  task automatic t_off();    scen("off",    1'b0, 5'b11111, 5'b10101, 5'b00000, 2); endtask
  task automatic t_midreset();
    scen("pre", 1'b1, 5'b01110, 5'b10001, 5'b11111, 1);
    do_reset();
    scen("post", 1'b1, 5'b01110, 5'b10001, 5'b10000, 1);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nchk + 1, nfail);
      $finish;
    end
  end

  initial begin
    h0_hit = 0; h0_ins = 0; h0_k = 0; h0_mask = '0; h0_dflt = '0; h0_din = 0;
    h0_link = 0; exp_rlink = 0;
    @(negedge clk);
    do_reset();
    t_full();
    t_single();
    t_sparse();
    t_off();
    t_midreset();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule